// File: doc/BRIEF.md
# Dual-Protocol Host Register Port

This block gives an asynchronous host processor access to a small bank of 8-bit control registers over a shared parallel bus. The same pins serve two bus styles. In strobe mode the host uses separate read and write strobes and waits on a ready output. In data-strobe mode the host uses one data strobe, a read/write level and an acknowledge output. A static mode input picks the style.

All host control pins are first brought into the internal clock through two flip-flop stages. Only the synchronized copies start an access. A read captures the addressed register and drives it onto the bidirectional data bus. A write stores the bus value into the addressed register. The whole bank is also brought out as a flat vector, so the surrounding logic can use it.

Top module: `host_microport`

## Requirements
- R1: After reset all registers read as 0x00, `status` is high and the data bus is not driven.
- R2: In strobe mode (`bus_moto`=0), `cs_n` low with `strb_a_n` low is a read. The addressed register appears on `data` once `status` has returned high after its low pulse.
- R3: In strobe mode, `cs_n` low with `ctl_b` low is a write. The addressed register takes the bus value that was present just before the synchronized rising edge of `ctl_b`. It is not updated while `ctl_b` is still low.
- R4: In data-strobe mode (`bus_moto`=1), `cs_n` low with `strb_a_n` low and `ctl_b` low writes the bus value into the addressed register.
- R5: In data-strobe mode, `cs_n` low with `strb_a_n` low and `ctl_b` high drives the addressed register onto `data`.
- R6: In data-strobe mode, `status` (acknowledge, active low) goes low three clock edges after the strobe falls. It stays low while the strobe is held, and returns high two edges after the strobe rises.
- R7: With `cs_n` high, the strobes have no effect: no register changes, `status` stays high and the data bus is not driven.
- R8: Host control pins pass through two synchronizer stages. In strobe mode, `status` goes low two clock edges after a strobe falls.
- R9: In strobe mode, `status` (ready) is low for exactly one clock per access and then stays high.
- R10: `regs_o` carries register n in bits [8n+7:8n] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_moto | input | 1 | Bus style: 0 = read/write strobes with ready, 1 = data strobe with acknowledge |
| cs_n | input | 1 | Chip select, active low |
| strb_a_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| ctl_b | input | 1 | Write strobe, active low (mode 0), or read/write level, 1 = read (mode 1) |
| addr | input | 3 | Register address |
| data | inout | 8 | Bidirectional host data bus |
| status | output | 1 | Ready (mode 0) or acknowledge, active low (mode 1) |
| regs_o | output | 64 | All registers, flattened |

## Verification
The bench builds the block with its default 8-bit data width and 3-bit address. This gives the full eight-register bank, so every address in both bus styles can be written and read back through a vector table. The small depth also lets the bench mirror the entire bank in its own model and compare `regs_o` after each access. Directed tests cover the edge-exact timing of the ready pulse and the acknowledge. They also cover deselected strobes and the rule that a strobe-mode write is deferred until the write strobe rises.

// File: rtl/host_microport.sv
module host_microport #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_moto,
  input  logic                  cs_n,
  input  logic                  strb_a_n,
  input  logic                  ctl_b,
  input  logic [AW-1:0]         addr,
  inout  wire  [DW-1:0]         data,
  output logic                  status,
  output logic [(DW<<AW)-1:0]   regs_o
);
  localparam int NREG = 1 << AW;

  logic [1:0] cs_sy, a_sy, b_sy;
  logic [DW-1:0] bank [NREG];
  logic [DW-1:0] rd_q, wd_q;
  logic [AW-1:0] wa_q;
  logic done, wr_pend;

  wire cs_s = cs_sy[1];
  wire a_s  = a_sy[1];
  wire b_s  = b_sy[1];

  wire active = !cs_s && (!a_s || (!bus_moto && !b_s));
  wire is_rd  = bus_moto ? b_s : !a_s;
  wire start  = active && !done;
  wire oe     = active && done && is_rd;

  assign data   = oe ? rd_q : {DW{1'bz}};
  assign status = bus_moto ? !(active && done) : !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b11;
      a_sy  <= 2'b11;
      b_sy  <= 2'b11;
    end else begin
      cs_sy <= {cs_sy[0], cs_n};
      a_sy  <= {a_sy[0], strb_a_n};
      b_sy  <= {b_sy[0], ctl_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      wr_pend <= 1'b0;
      rd_q    <= '0;
      wd_q    <= '0;
      wa_q    <= '0;
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else begin
      done <= active;
      if (start && is_rd) rd_q <= bank[addr];
      if (start && !is_rd && bus_moto) bank[addr] <= data;
      if (active && !is_rd && !bus_moto) begin
        wr_pend <= 1'b1;
        wa_q    <= addr;
        wd_q    <= data;
      end else if (wr_pend) begin
        bank[wa_q] <= wd_q;
        wr_pend    <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DW +: DW] = bank[g];
  end

  // R9
  ready_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_moto && !status) |=> status);

  // R6
  ack_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_moto && !status) |-> $past(active));

  // R3
  deferred_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !active) |=> !wr_pend);

  // R8
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R2
  drive_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> $past(active));
endmodule

// File: tb/test_host_microport.sv
module test_host_microport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_moto = 1'b0, cs_n = 1'b1, strb_a_n = 1'b1, ctl_b = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] tb_d = '0;
  logic tb_oe = 1'b0;
  wire  [7:0] data;
  logic status;
  logic [63:0] regs_o;
  logic [7:0] model [8];
  int checks = 0, errors = 0, cyc = 0;

  assign data = tb_oe ? tb_d : 8'bz;

  always #10 clk = ~clk;

  host_microport i_host_microport (
    .clk(clk), .rst_n(rst_n), .bus_moto(bus_moto), .cs_n(cs_n),
    .strb_a_n(strb_a_n), .ctl_b(ctl_b), .addr(addr), .data(data),
    .status(status), .regs_o(regs_o)
  );

  // vector: {moto, write, addr[2:0], data[7:0]}
  localparam logic [12:0] VEC [12] = '{
    {1'b0, 1'b1, 3'd0, 8'hA5}, {1'b0, 1'b1, 3'd3, 8'h3C},
    {1'b1, 1'b1, 3'd5, 8'hF0}, {1'b1, 1'b1, 3'd7, 8'h81},
    {1'b0, 1'b0, 3'd0, 8'h00}, {1'b1, 1'b0, 3'd3, 8'h00},
    {1'b0, 1'b0, 3'd5, 8'h00}, {1'b1, 1'b0, 3'd7, 8'h00},
    {1'b1, 1'b1, 3'd0, 8'h5A}, {1'b0, 1'b1, 3'd7, 8'h18},
    {1'b0, 1'b0, 3'd7, 8'h00}, {1'b1, 1'b0, 3'd0, 8'h00}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [63:0] flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic intel_write(input logic [2:0] a, input logic [7:0] d);
    bus_moto = 1'b0; addr = a; tb_d = d; tb_oe = 1'b1; cs_n = 1'b0; ctl_b = 1'b0;
    wait_n(2);
    chk("R8", status, 0);
    wait_n(1);
    chk("R9", status, 1);
    wait_n(2);
    chk("R3 no early write", regs_o[a*8 +: 8], model[a]);
    ctl_b = 1'b1;
    wait_n(3);
    cs_n = 1'b1; tb_oe = 1'b0;
    model[a] = d;
    wait_n(1);
    chk("R3", regs_o[a*8 +: 8], d);
    wait_n(2);
  endtask

  task automatic intel_read(input logic [2:0] a);
    bus_moto = 1'b0; addr = a; cs_n = 1'b0; strb_a_n = 1'b0;
    wait_n(2);
    chk("R9 low", status, 0);
    wait_n(1);
    chk("R2", data, model[a]);
    cs_n = 1'b1; strb_a_n = 1'b1;
    wait_n(3);
  endtask

  task automatic moto_write(input logic [2:0] a, input logic [7:0] d);
    bus_moto = 1'b1; addr = a; tb_d = d; tb_oe = 1'b1; ctl_b = 1'b0;
    cs_n = 1'b0; strb_a_n = 1'b0;
    wait_n(2);
    chk("R6 not yet", status, 1);
    wait_n(1);
    chk("R6 ack", status, 0);
    model[a] = d;
    chk("R4", regs_o[a*8 +: 8], d);
    strb_a_n = 1'b1; cs_n = 1'b1;
    wait_n(1);
    chk("R6 held", status, 0);
    wait_n(1);
    chk("R6 release", status, 1);
    tb_oe = 1'b0; ctl_b = 1'b1;
    wait_n(2);
  endtask

  task automatic moto_read(input logic [2:0] a);
    bus_moto = 1'b1; addr = a; ctl_b = 1'b1; cs_n = 1'b0; strb_a_n = 1'b0;
    wait_n(3);
    chk("R6 ack rd", status, 0);
    chk("R5", data, model[a]);
    strb_a_n = 1'b1; cs_n = 1'b1;
    wait_n(3);
    chk("R6 idle", status, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 regs", regs_o, 64'h0);
    chk("R1 status", status, 1);
    for (int v = 0; v < 12; v++) begin
      if (VEC[v][12]) begin
        if (VEC[v][11]) moto_write(VEC[v][10:8], VEC[v][7:0]);
        else            moto_read(VEC[v][10:8]);
      end else begin
        if (VEC[v][11]) intel_write(VEC[v][10:8], VEC[v][7:0]);
        else            intel_read(VEC[v][10:8]);
      end
      chk("R10", regs_o, flat());
    end
    // R7: deselected strobes; register 2 holds FF, bench drives 00
    intel_write(3'd2, 8'hFF);
    bus_moto = 1'b0; addr = 3'd2; tb_d = 8'h00; tb_oe = 1'b1;
    cs_n = 1'b1; strb_a_n = 1'b0;
    wait_n(4);
    chk("R7 status", status, 1);
    chk("R7 bus", data, 8'h00);
    strb_a_n = 1'b1; ctl_b = 1'b0;
    wait_n(4);
    ctl_b = 1'b1;
    wait_n(4);
    chk("R7 no write", regs_o, flat());
    bus_moto = 1'b1; ctl_b = 1'b0; strb_a_n = 1'b0;
    wait_n(4);
    chk("R7 moto status", status, 1);
    strb_a_n = 1'b1; ctl_b = 1'b1; tb_oe = 1'b0;
    wait_n(3);
    chk("R7 moto no write", regs_o, flat());
    // R1: reset clears the bank
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    chk("R1 reset again", regs_o, 64'h0);
    intel_read(3'd2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule